// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block takes a stream of instruction bytes, one byte per valid/ready handshake. It splits each instruction into its fields and presents one decoded record per instruction. A record starts with any number of prefix bytes, up to a fixed limit. After them come the opcode byte, an optional addressing-mode byte, up to two displacement bytes and up to two immediate bytes. The parser walks these fields one state at a time. Which later bytes it expects depends on the opcode class, the mode and register/memory fields of the addressing-mode byte, and the word bit. Two-byte quantities are assembled low byte first.

The record holds the following:
- the prefix flags, with the most recent segment override kept;
- the raw opcode and its direction and word bits;
- the mode, register and register/memory fields;
- the assembled displacement and immediate values;
- the byte count of the whole instruction, prefixes included.

Only a small set of opcodes is decoded: register/memory moves, the pop forms, and move-immediate to register/memory. Any other opcode closes the record at once with an unsupported flag. The following byte then starts a new instruction.

A finished record is held on the outputs until the consumer accepts it. Input ready is low for as long as a record is held, so the producer simply stalls.

Top module: `ibyte_parser`

## Requirements
- R1: After reset, and after a reset in the middle of an instruction, out_valid is 0 and in_ready is 1. The first record produced afterwards carries no state from before the reset.
- R2: Prefix bytes set flags. F3 sets out_rep, F2 sets out_repne, F0 sets out_lock, 66 sets out_opsz and 67 sets out_adsz. A segment byte sets out_seg_v and puts a code on out_seg: 26 gives 0, 2E gives 1, 36 gives 2 and 3E gives 3. When several segment bytes appear, the latest one wins. Prefixes may come in any order.
- R3: out_d is opcode bit 1 and out_w is opcode bit 0, for every record. From the addressing-mode byte, out_mod is bits 7:6, out_reg is bits 5:3 and out_rm is bits 2:0.
- R4: The displacement is read from the bytes after the addressing-mode byte, as follows:
  - mode 00 with r/m 110: two bytes;
  - mode 01: one byte, sign-extended to 16 bits;
  - mode 10: two bytes;
  - mode 11, or mode 00 with any other r/m: none.
  Two-byte values are taken low byte first.
- R5: Opcodes 88 to 8B (100010dw) take an addressing-mode byte and have no immediate, so out_imm is 0.
- R6: Opcodes C6 and C7 take an addressing-mode byte, then the displacement, then the immediate. C6 has one immediate byte, zero-extended. C7 has two immediate bytes, low byte first.
- R7: Opcode 8F takes an addressing-mode byte and its displacement. Opcodes 58 to 5F, 07, 17 and 1F are one byte long, and their mode, register, register/memory, displacement and immediate fields all read 0.
- R8: Any other opcode ends the record after the opcode byte. It sets out_unsup to 1 and leaves the addressing-mode, displacement and immediate fields at 0. The next byte is parsed as the start of a new instruction.
- R9: out_len equals the number of bytes the record consumed, prefixes included.
- R10: At most four prefix bytes are taken as prefixes. A fifth prefix-coded byte is handled as an unsupported opcode, which gives out_len 5 with out_unsup set.
- R11: While out_valid is 1 and out_ready is 0, every record output holds its value and in_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser can take a byte |
| out_valid | output | 1 | Record complete and held |
| out_ready | input | 1 | Consumer takes the record |
| out_rep | output | 1 | Repeat (F3) prefix seen |
| out_repne | output | 1 | Repeat-while-not-equal (F2) prefix seen |
| out_lock | output | 1 | Lock prefix seen |
| out_opsz | output | 1 | Operand-size override seen |
| out_adsz | output | 1 | Address-size override seen |
| out_seg_v | output | 1 | A segment override was seen |
| out_seg | output | 2 | Latest segment override code |
| out_opcode | output | 8 | Opcode byte |
| out_d | output | 1 | Opcode bit 1 |
| out_w | output | 1 | Opcode bit 0 |
| out_mod | output | 2 | Mode field |
| out_reg | output | 3 | Register field |
| out_rm | output | 3 | Register/memory field |
| out_disp | output | 16 | Assembled displacement |
| out_imm | output | 16 | Assembled immediate |
| out_len | output | LEN_W (4) | Total byte count |
| out_unsup | output | 1 | Opcode outside the decoded set |

## Verification
The hardest situation to reach is a prefix-coded byte arriving after the prefix limit is full. It must be taken as an opcode and not as a fifth prefix. The stimulus sends five identical lock bytes in a row and then expects an unsupported record of length five.

A second hard case is recovery after an unsupported record. A record with only prefixes and an unknown opcode is sent straight after such a record, and its length and flags must show that the parser started fresh.

The bench also tests several other cases:
- idle gaps between bytes;
- holding a record on the outputs for several cycles;
- a reset in the middle of an instruction.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

  typedef enum logic [2:0] {
    ST_OPC, ST_MRM, ST_DLO, ST_DHI, ST_ILO, ST_IHI, ST_HOLD
  } st_e;

  typedef enum logic [1:0] {
    OC_UNSUP, OC_ONE, OC_MRM, OC_MRM_IMM
  } ocls_e;

  typedef struct packed {
    logic       rep;
    logic       repne;
    logic       lock;
    logic       opsz;
    logic       adsz;
    logic       seg_v;
    logic [1:0] seg;
  } pfx_t;

  function automatic logic is_prefix(input logic [7:0] b);
    case (b)
      8'hF3, 8'hF2, 8'hF0, 8'h66, 8'h67,
      8'h26, 8'h2E, 8'h36, 8'h3E: is_prefix = 1'b1;
      default:                    is_prefix = 1'b0;
    endcase
  endfunction

  // {valid, code}: ES=0, CS=1, SS=2, DS=3
  function automatic logic [2:0] seg_of(input logic [7:0] b);
    case (b)
      8'h26:   seg_of = 3'b100;
      8'h2E:   seg_of = 3'b101;
      8'h36:   seg_of = 3'b110;
      8'h3E:   seg_of = 3'b111;
      default: seg_of = 3'b000;
    endcase
  endfunction

  function automatic ocls_e classify(input logic [7:0] op);
    if (op[7:2] == 6'b100010)                   classify = OC_MRM;
    else if (op == 8'h8F)                       classify = OC_MRM;
    else if (op[7:1] == 7'b1100011)             classify = OC_MRM_IMM;
    else if (op[7:3] == 5'b01011)               classify = OC_ONE;
    else if (op == 8'h07 || op == 8'h17 || op == 8'h1F) classify = OC_ONE;
    else                                        classify = OC_UNSUP;
  endfunction

  function automatic logic [1:0] disp_bytes(input logic [1:0] md, input logic [2:0] rm);
    case (md)
      2'b00:   disp_bytes = (rm == 3'b110) ? 2'd2 : 2'd0;
      2'b01:   disp_bytes = 2'd1;
      2'b10:   disp_bytes = 2'd2;
      default: disp_bytes = 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] imm_bytes(input ocls_e c, input logic w);
    if (c == OC_MRM_IMM) imm_bytes = w ? 2'd2 : 2'd1;
    else                 imm_bytes = 2'd0;
  endfunction

  function automatic logic [15:0] sext8(input logic [7:0] b);
    sext8 = {{8{b[7]}}, b};
  endfunction

endpackage

// File: rtl/ibp_prefix_acc.sv
module ibp_prefix_acc
  import ibp_pkg::*;
#(
  parameter int MAX_PFX = 4,
  localparam int CNT_W = $clog2(MAX_PFX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             clr,
  input  logic [7:0]       pbyte,
  output pfx_t             flags,
  output logic [CNT_W-1:0] cnt,
  output logic             room
);

  logic [2:0] seg_code;
  assign seg_code = seg_of(pbyte);
  assign room     = (cnt < CNT_W'(MAX_PFX));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      flags <= '0;
      cnt   <= '0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      case (pbyte)
        8'hF3:   flags.rep   <= 1'b1;
        8'hF2:   flags.repne <= 1'b1;
        8'hF0:   flags.lock  <= 1'b1;
        8'h66:   flags.opsz  <= 1'b1;
        8'h67:   flags.adsz  <= 1'b1;
        default: begin
          if (seg_code[2]) begin
            flags.seg_v <= 1'b1;
            flags.seg   <= seg_code[1:0];
          end
        end
      endcase
    end
  end

  AST_PFX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_PFX)); // R10

  AST_SEG_LATEST: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && seg_code[2]) |=> (flags.seg_v && flags.seg == $past(seg_code[1:0]))); // R2

endmodule

// File: rtl/ibp_seq.sv
module ibp_seq
  import ibp_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  input  logic             pfx_room,
  output logic             pfx_take,
  output logic             rec_done,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       opc_q,
  output logic [7:0]       mrm_q,
  output logic [15:0]      disp_q,
  output logic [15:0]      imm_q,
  output logic [LEN_W-1:0] len_q,
  output logic             unsup_q
);

  st_e        st;
  logic       byte_acc;
  ocls_e      cls_in, cls_q;
  logic [1:0] dn_in, dn_q, in_n;

  assign in_ready  = (st != ST_HOLD);
  assign out_valid = (st == ST_HOLD);
  assign byte_acc  = in_valid && in_ready;
  assign rec_done  = out_valid && out_ready;
  assign pfx_take  = byte_acc && (st == ST_OPC) && is_prefix(in_byte) && pfx_room;

  assign cls_in = classify(in_byte);
  assign cls_q  = classify(opc_q);
  assign dn_in  = disp_bytes(in_byte[7:6], in_byte[2:0]);
  assign dn_q   = disp_bytes(mrm_q[7:6], mrm_q[2:0]);
  assign in_n   = imm_bytes(cls_q, opc_q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_OPC;
      opc_q   <= '0;
      mrm_q   <= '0;
      disp_q  <= '0;
      imm_q   <= '0;
      len_q   <= '0;
      unsup_q <= 1'b0;
    end else begin
      if (byte_acc) len_q <= len_q + 1'b1;
      case (st)
        ST_OPC: if (byte_acc && !pfx_take) begin
          opc_q <= in_byte;
          case (cls_in)
            OC_UNSUP: begin unsup_q <= 1'b1; st <= ST_HOLD; end
            OC_ONE:   st <= ST_HOLD;
            default:  st <= ST_MRM;
          endcase
        end
        ST_MRM: if (byte_acc) begin
          mrm_q <= in_byte;
          if (dn_in != 2'd0)      st <= ST_DLO;
          else if (in_n != 2'd0)  st <= ST_ILO;
          else                    st <= ST_HOLD;
        end
        ST_DLO: if (byte_acc) begin
          if (dn_q == 2'd2) begin
            disp_q <= {8'h00, in_byte};
            st     <= ST_DHI;
          end else begin
            disp_q <= sext8(in_byte);
            st     <= (in_n != 2'd0) ? ST_ILO : ST_HOLD;
          end
        end
        ST_DHI: if (byte_acc) begin
          disp_q[15:8] <= in_byte;
          st           <= (in_n != 2'd0) ? ST_ILO : ST_HOLD;
        end
        ST_ILO: if (byte_acc) begin
          imm_q <= {8'h00, in_byte};
          st    <= (in_n == 2'd2) ? ST_IHI : ST_HOLD;
        end
        ST_IHI: if (byte_acc) begin
          imm_q[15:8] <= in_byte;
          st          <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) begin
          opc_q   <= '0;
          mrm_q   <= '0;
          disp_q  <= '0;
          imm_q   <= '0;
          len_q   <= '0;
          unsup_q <= 1'b0;
          st      <= ST_OPC;
        end
        default: st <= ST_OPC;
      endcase
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && !in_ready && $stable(opc_q) && $stable(mrm_q)
      && $stable(disp_q) && $stable(imm_q) && $stable(len_q))); // R11

  AST_DISP8_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && st == ST_DLO && dn_q == 2'd1) |=> (disp_q[15:8] == {8{disp_q[7]}})); // R4

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (len_q != '0)); // R9

endmodule

// File: rtl/ibyte_parser.sv
module ibyte_parser
  import ibp_pkg::*;
#(
  parameter int MAX_PFX = 4,
  localparam int CNT_W = $clog2(MAX_PFX + 1),
  localparam int LEN_W = $clog2(MAX_PFX + 7)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_rep,
  output logic             out_repne,
  output logic             out_lock,
  output logic             out_opsz,
  output logic             out_adsz,
  output logic             out_seg_v,
  output logic [1:0]       out_seg,
  output logic [7:0]       out_opcode,
  output logic             out_d,
  output logic             out_w,
  output logic [1:0]       out_mod,
  output logic [2:0]       out_reg,
  output logic [2:0]       out_rm,
  output logic [15:0]      out_disp,
  output logic [15:0]      out_imm,
  output logic [LEN_W-1:0] out_len,
  output logic             out_unsup
);

  pfx_t             flags;
  logic [CNT_W-1:0] pfx_cnt;
  logic             pfx_room, pfx_take, rec_done;
  logic [7:0]       mrm;

  ibp_prefix_acc #(.MAX_PFX(MAX_PFX)) u_pfx (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (pfx_take),
    .clr   (rec_done),
    .pbyte (in_byte),
    .flags (flags),
    .cnt   (pfx_cnt),
    .room  (pfx_room)
  );

  ibp_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .in_ready  (in_ready),
    .pfx_room  (pfx_room),
    .pfx_take  (pfx_take),
    .rec_done  (rec_done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .opc_q     (out_opcode),
    .mrm_q     (mrm),
    .disp_q    (out_disp),
    .imm_q     (out_imm),
    .len_q     (out_len),
    .unsup_q   (out_unsup)
  );

  assign out_rep   = flags.rep;
  assign out_repne = flags.repne;
  assign out_lock  = flags.lock;
  assign out_opsz  = flags.opsz;
  assign out_adsz  = flags.adsz;
  assign out_seg_v = flags.seg_v;
  assign out_seg   = flags.seg;
  assign out_d     = out_opcode[1];
  assign out_w     = out_opcode[0];
  assign out_mod   = mrm[7:6];
  assign out_reg   = mrm[5:3];
  assign out_rm    = mrm[2:0];

  // expected length rebuilt from the record's own fields
  ocls_e            rec_cls;
  logic [LEN_W-1:0] body_len, sum_len;
  assign rec_cls  = classify(out_opcode);
  assign body_len = LEN_W'(1)
                  + ((rec_cls == OC_ONE) ? LEN_W'(0) : LEN_W'(1))
                  + LEN_W'(disp_bytes(out_mod, out_rm))
                  + LEN_W'(imm_bytes(rec_cls, out_w));
  assign sum_len  = LEN_W'(pfx_cnt) + body_len;

  AST_LEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_unsup) |-> (out_len == sum_len)); // R9

  AST_UNSUP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unsup) |-> (out_len == LEN_W'(pfx_cnt) + LEN_W'(1)
      && mrm == 8'h00 && out_disp == 16'h0 && out_imm == 16'h0)); // R8

  AST_CLEAN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> (out_len == '0 && !out_seg_v && !out_lock)); // R1

endmodule

// File: tb/ibyte_parser_bench.sv
`timescale 1ns/100ps
module ibyte_parser_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, out_valid;
  logic        out_ready = 1'b0;
  logic        out_rep, out_repne, out_lock, out_opsz, out_adsz, out_seg_v;
  logic [1:0]  out_seg, out_mod;
  logic [7:0]  out_opcode;
  logic        out_d, out_w, out_unsup;
  logic [2:0]  out_reg, out_rm;
  logic [15:0] out_disp, out_imm;
  logic [3:0]  out_len;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ibyte_parser u_ibyte_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_rep(out_rep), .out_repne(out_repne), .out_lock(out_lock),
    .out_opsz(out_opsz), .out_adsz(out_adsz), .out_seg_v(out_seg_v),
    .out_seg(out_seg), .out_opcode(out_opcode), .out_d(out_d), .out_w(out_w),
    .out_mod(out_mod), .out_reg(out_reg), .out_rm(out_rm), .out_disp(out_disp),
    .out_imm(out_imm), .out_len(out_len), .out_unsup(out_unsup)
  );

  typedef struct packed {
    logic [3:0]  nb;
    logic [79:0] bytes;   // first byte in [79:72]
    logic [7:0]  pfx;     // rep,repne,lock,opsz,adsz,seg_v,seg[1:0]
    logic [7:0]  opc;
    logic [1:0]  dw;
    logic [7:0]  mrm;
    logic [15:0] disp;
    logic [15:0] imm;
    logic [3:0]  len;
    logic        unsup;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    '{4'd2, {16'h89D8, 64'h0},       8'h00, 8'h89, 2'b01, 8'hD8, 16'h0000, 16'h0000, 4'd2, 1'b0, 4'd3}, // R3
    '{4'd2, {16'h8BC3, 64'h0},       8'h00, 8'h8B, 2'b11, 8'hC3, 16'h0000, 16'h0000, 4'd2, 1'b0, 4'd3}, // R3
    '{4'd3, {24'h884F10, 56'h0},     8'h00, 8'h88, 2'b00, 8'h4F, 16'h0010, 16'h0000, 4'd3, 1'b0, 4'd4}, // R4
    '{4'd3, {24'h884FF0, 56'h0},     8'h00, 8'h88, 2'b00, 8'h4F, 16'hFFF0, 16'h0000, 4'd3, 1'b0, 4'd4}, // R4 sign
    '{4'd4, {32'h888F3412, 48'h0},   8'h00, 8'h88, 2'b00, 8'h8F, 16'h1234, 16'h0000, 4'd4, 1'b0, 4'd4}, // R4 mode 10
    '{4'd4, {32'h8B06452A, 48'h0},   8'h00, 8'h8B, 2'b11, 8'h06, 16'h2A45, 16'h0000, 4'd4, 1'b0, 4'd4}, // R4 direct
    '{4'd2, {16'h8B07, 64'h0},       8'h00, 8'h8B, 2'b11, 8'h07, 16'h0000, 16'h0000, 4'd2, 1'b0, 4'd5}, // R5
    '{4'd5, {40'hC606000110, 40'h0}, 8'h00, 8'hC6, 2'b10, 8'h06, 16'h0100, 16'h0010, 4'd5, 1'b0, 4'd6}, // R6
    '{4'd5, {40'hC747FE3412, 40'h0}, 8'h00, 8'hC7, 2'b11, 8'h47, 16'hFFFE, 16'h1234, 4'd5, 1'b0, 4'd6}, // R6
    '{4'd4, {32'hC7C0CDAB, 48'h0},   8'h00, 8'hC7, 2'b11, 8'hC0, 16'h0000, 16'hABCD, 4'd4, 1'b0, 4'd6}, // R6
    '{4'd2, {16'h8FC0, 64'h0},       8'h00, 8'h8F, 2'b11, 8'hC0, 16'h0000, 16'h0000, 4'd2, 1'b0, 4'd7}, // R7
    '{4'd4, {32'h8F060012, 48'h0},   8'h00, 8'h8F, 2'b11, 8'h06, 16'h1200, 16'h0000, 4'd4, 1'b0, 4'd7}, // R7
    '{4'd5, {40'h2E8F060012, 40'h0}, 8'h05, 8'h8F, 2'b11, 8'h06, 16'h1200, 16'h0000, 4'd5, 1'b0, 4'd2}, // R2 R9
    '{4'd1, {8'h5B, 72'h0},          8'h00, 8'h5B, 2'b11, 8'h00, 16'h0000, 16'h0000, 4'd1, 1'b0, 4'd7}, // R7
    '{4'd1, {8'h1F, 72'h0},          8'h00, 8'h1F, 2'b11, 8'h00, 16'h0000, 16'h0000, 4'd1, 1'b0, 4'd7}, // R7
    '{4'd1, {8'h07, 72'h0},          8'h00, 8'h07, 2'b11, 8'h00, 16'h0000, 16'h0000, 4'd1, 1'b0, 4'd7}, // R7
    '{4'd6, {48'hF3F2F0668B07, 32'h0}, 8'hF0, 8'h8B, 2'b11, 8'h07, 16'h0000, 16'h0000, 4'd6, 1'b0, 4'd2}, // R2 R9
    '{4'd5, {40'h263E6789D8, 40'h0}, 8'h0F, 8'h89, 2'b01, 8'hD8, 16'h0000, 16'h0000, 4'd5, 1'b0, 4'd2}, // R2 latest seg
    '{4'd1, {8'h90, 72'h0},          8'h00, 8'h90, 2'b00, 8'h00, 16'h0000, 16'h0000, 4'd1, 1'b1, 4'd8}, // R8
    '{4'd2, {16'h660F, 64'h0},       8'h10, 8'h0F, 2'b11, 8'h00, 16'h0000, 16'h0000, 4'd2, 1'b1, 4'd8}, // R8 resync
    '{4'd5, {40'hF0F0F0F0F0, 40'h0}, 8'h20, 8'hF0, 2'b00, 8'h00, 16'h0000, 16'h0000, 4'd5, 1'b1, 4'd10}, // R10
    '{4'd5, {40'h362E8A46FC, 40'h0}, 8'h05, 8'h8A, 2'b10, 8'h46, 16'hFFFC, 16'h0000, 4'd5, 1'b0, 4'd4}  // R4 R2
  };

  logic [62:0] act;
  assign act = {out_rep, out_repne, out_lock, out_opsz, out_adsz, out_seg_v, out_seg,
                out_opcode, out_d, out_w, out_mod, out_reg, out_rm,
                out_disp, out_imm, out_len, out_unsup};

  task automatic check(input bit ok, input string req, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit gap);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic take_rec(output logic [62:0] rec);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    rec = act;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [62:0] rec, exp, held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", {62'b0, out_valid, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", {62'b0, out_valid, in_ready}, 64'h1);

    // table walk: R2..R10
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < TBL[i].nb; k++)
        send(TBL[i].bytes[79 - 8*k -: 8], (i % 3) == 1);
      take_rec(rec);
      exp = {TBL[i].pfx, TBL[i].opc, TBL[i].dw, TBL[i].mrm, TBL[i].disp, TBL[i].imm,
             TBL[i].len, TBL[i].unsup};
      check(rec == exp, $sformatf("R%0d vec%0d", TBL[i].req, i), {1'b0, rec}, {1'b0, exp});
    end

    // R11: record held while consumer stalls
    send(8'h89, 1'b0);
    send(8'hD8, 1'b0);
    held = act;
    repeat (5) @(negedge clk);
    check(out_valid && !in_ready, "R11 hold", {62'b0, out_valid, in_ready}, 64'h2);
    check(act == held, "R11 stable", {1'b0, act}, {1'b0, held});
    take_rec(rec);
    exp = {8'h00, 8'h89, 2'b01, 8'hD8, 16'h0, 16'h0, 4'd2, 1'b0};
    check(rec == exp, "R11 release", {1'b0, rec}, {1'b0, exp});

    // R1: reset in the middle of an instruction
    send(8'h2E, 1'b0);
    send(8'hC7, 1'b0);
    send(8'h47, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 midreset", {62'b0, out_valid, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    send(8'h5B, 1'b0);
    take_rec(rec);
    exp = {8'h00, 8'h5B, 2'b11, 8'h00, 16'h0, 16'h0, 4'd1, 1'b0};
    check(rec == exp, "R1 clean", {1'b0, rec}, {1'b0, exp});

    summary();
    $finish;
  end

endmodule